// File: doc/BRIEF.md
# Temperature Channel Plausibility Monitor

This block watches a stream of multiplexed temperature readings for faults in the measurement chain rather than for high temperatures. Each reading arrives as a channel index, a raw converter code and a valid strobe. A separate flag on the same strobe says that a digital sensor did not answer in time. The block keeps one sticky fault bit per channel. It also raises a single trip-level output when any channel that software has marked as essential is faulted.

Three kinds of fault set a channel's bit. The first is a code pinned near either end of the converter range, which points to an open or shorted probe. The second is a reading that stays frozen while a companion channel moves clearly, which exposes a stuck input that a range check would miss. The third is a digital sensor whose run of consecutive timeouts passes a retry limit. Margins, deltas, window length, retry limit, neighbour mapping, digital-channel mask and key mask are all configuration inputs. A clear vector releases fault bits, one per channel.

Top module: `tsense_guard`

## Requirements
- R1: A valid non-timeout reading whose code is at most `railMargin`, or at least the full-scale code minus `railMargin`, sets `sensorFault[ch]` on the clock edge that accepts it. Bit i of `sensorFault` belongs to channel i.
- R2: A reading opens a fresh window when it differs from the channel's anchor code by more than `stillDelta`, and it then becomes the new anchor. Otherwise it counts as a still sample. On the `stuckSamples`-th still sample after the anchor, the channel is flagged stuck if its neighbour's latest code differs by more than `moveDelta` from the neighbour code captured at the anchor.
- R3: A channel that stays still while its neighbour also stays within `moveDelta` is never flagged stuck.
- R4: By default, the neighbour of channel N is channel N+1, and the last channel wraps to channel 0.
- R5: When `nbrOverride[N]` is 1, channel N uses the neighbour index held in `nbrIndex[N*CH_W +: CH_W]`.
- R6: For a channel whose `digitalMask` bit is 1, a timeout strobe sets its fault bit once the run of consecutive timeouts exceeds `retryLimit`. With a limit of 3, the fourth timeout sets it.
- R7: A valid non-timeout reading resets that channel's consecutive-timeout count to zero.
- R8: Timeout strobes on a channel whose `digitalMask` bit is 0 have no effect.
- R9: Fault bits are sticky. A 1 in `clearFault[i]` for one cycle clears bit i. A fault detected in the same cycle takes priority over the clear.
- R10: `keyLost` is 1 exactly when some channel with a 1 in `keyMask` has its fault bit set.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low reset |
| sampleValid | input | 1 | Strobe for one reading or timeout event |
| sampleCh | input | CH_W | Channel of the event |
| sampleCode | input | CODE_W | Raw converter code |
| sampleTimeout | input | 1 | Event is a digital-sensor timeout, not a reading |
| railMargin | input | CODE_W | Distance from either rail treated as open/short |
| stillDelta | input | CODE_W | Largest change still counted as frozen |
| moveDelta | input | CODE_W | Neighbour change must exceed this |
| stuckSamples | input | STILL_W | Still samples needed to call a channel stuck |
| retryLimit | input | RETRY_W | Timeouts allowed before flagging |
| digitalMask | input | NUM_CH | Channels that are digital sensors |
| keyMask | input | NUM_CH | Channels whose loss drives keyLost |
| nbrOverride | input | NUM_CH | Use the programmed neighbour index |
| nbrIndex | input | NUM_CH*CH_W | Programmed neighbour per channel |
| clearFault | input | NUM_CH | Per-channel clear pulse |
| sensorFault | output | NUM_CH | Sticky per-channel fault bits |
| keyLost | output | 1 | Key sensor lost, trip request |

## Verification
The bench sweeps codes across both rail boundaries, one step at a time. A comparison that is off by one would flag one code too many or too few at the margin edge. Stuck detection is driven with moving and quiet neighbours, through the default, wrapped and overridden neighbour paths. This catches a design that flags one sample early or late, or that ignores movement on the neighbour. Timeout runs test the exact retry count that trips, the reset of the count by a good read in the middle of a run, and timeouts on analog channels that must not count. The tests also check sticky hold, a clear on one bit that leaves the others intact, and keyLost following only the masked channels.

// File: rtl/tsg_pkg.sv
package tsg_pkg;
  // Strobes the control half hands to the datapath each cycle.
  typedef struct packed {
    logic readEn;   // valid reading, not a timeout
    logic toTrip;   // timeout run on the addressed channel passed the limit
  } tsgStrobe_t;
endpackage

// File: rtl/tsg_ctrl.sv
module tsg_ctrl #(
  parameter int NUM_CH  = 4,
  parameter int RETRY_W = 4,
  localparam int CH_W   = (NUM_CH > 1) ? $clog2(NUM_CH) : 1
) (
  input  logic                clk,
  input  logic                rst_n,
  input  logic                sampleValid,
  input  logic                sampleTimeout,
  input  logic [CH_W-1:0]     sampleCh,
  input  logic [NUM_CH-1:0]   digitalMask,
  input  logic [RETRY_W-1:0]  retryLimit,
  output tsg_pkg::tsgStrobe_t strobe
);
  logic [RETRY_W-1:0] retryCnt [NUM_CH];
  logic [RETRY_W:0]   nextCount;
  logic               isDigital;

  assign isDigital = digitalMask[sampleCh];
  assign nextCount = {1'b0, retryCnt[sampleCh]} + 1'b1;

  always_comb begin
    strobe.readEn = sampleValid && !sampleTimeout;
    strobe.toTrip = sampleValid && sampleTimeout && isDigital &&
                    (nextCount > {1'b0, retryLimit});
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      for (int c = 0; c < NUM_CH; c++) retryCnt[c] <= '0;
    end else if (sampleValid) begin
      for (int c = 0; c < NUM_CH; c++) begin
        if (sampleCh == CH_W'(c)) begin
          if (!sampleTimeout)
            retryCnt[c] <= '0;
          else if (digitalMask[c] && retryCnt[c] != '1)
            retryCnt[c] <= retryCnt[c] + 1'b1;
        end
      end
    end
  end

  // R6
  trip_src_chk: assert property (@(posedge clk) disable iff (!rst_n)
    strobe.toTrip |-> (sampleValid && sampleTimeout && digitalMask[sampleCh]));

  // R7
  retry_reset_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (sampleValid && !sampleTimeout) |=> (retryCnt[$past(sampleCh)] == '0));
endmodule

// File: rtl/tsg_dpath.sv
module tsg_dpath #(
  parameter int NUM_CH  = 4,
  parameter int CODE_W  = 12,
  parameter int STILL_W = 8,
  localparam int CH_W   = (NUM_CH > 1) ? $clog2(NUM_CH) : 1
) (
  input  logic                   clk,
  input  logic                   rst_n,
  input  tsg_pkg::tsgStrobe_t    strobe,
  input  logic [CH_W-1:0]        sampleCh,
  input  logic [CODE_W-1:0]      sampleCode,
  input  logic [CODE_W-1:0]      railMargin,
  input  logic [CODE_W-1:0]      stillDelta,
  input  logic [CODE_W-1:0]      moveDelta,
  input  logic [STILL_W-1:0]     stuckSamples,
  input  logic [NUM_CH-1:0]      nbrOverride,
  input  logic [NUM_CH*CH_W-1:0] nbrIndex,
  input  logic [NUM_CH-1:0]      clearFault,
  output logic [NUM_CH-1:0]      sensorFault
);
  localparam logic [CODE_W-1:0] CODE_MAX = '1;

  function automatic logic [CODE_W-1:0] absDiff(input logic [CODE_W-1:0] a,
                                                input logic [CODE_W-1:0] b);
    return (a > b) ? (a - b) : (b - a);
  endfunction

  logic [CODE_W-1:0]  lastCode [NUM_CH];
  logic [CODE_W-1:0]  anchor   [NUM_CH];
  logic [CODE_W-1:0]  nbrSnap  [NUM_CH];
  logic [STILL_W-1:0] stillCnt [NUM_CH];
  logic [NUM_CH-1:0]  seen, snapOk, faultQ;

  logic [NUM_CH-1:0]      selV, quietV, stuckV, seenNbrV, setV;
  logic [NUM_CH*CH_W-1:0] nbrV;
  logic                   railHit;

  assign railHit = (sampleCode <= railMargin) ||
                   (sampleCode >= (CODE_MAX - railMargin));

  for (genvar g = 0; g < NUM_CH; g++) begin : gCh
    logic [CH_W-1:0]  nbr;
    logic [CODE_W-1:0] dSelf;
    logic             nbrMoved, windowDone;
    assign nbr = nbrOverride[g] ? nbrIndex[g*CH_W +: CH_W]
                                : CH_W'((g + 1) % NUM_CH);
    assign dSelf      = absDiff(sampleCode, anchor[g]);
    assign nbrMoved   = snapOk[g] && (absDiff(lastCode[nbr], nbrSnap[g]) > moveDelta);
    assign windowDone = ({1'b0, stillCnt[g]} + 1'b1) >= {1'b0, stuckSamples};
    assign selV[g]     = strobe.readEn && (sampleCh == CH_W'(g));
    assign quietV[g]   = seen[g] && (dSelf <= stillDelta);
    assign seenNbrV[g] = seen[nbr];
    assign nbrV[g*CH_W +: CH_W] = nbr;
    assign stuckV[g]   = selV[g] && quietV[g] && windowDone && nbrMoved;
    assign setV[g]     = (selV[g] && (railHit || stuckV[g])) ||
                         (strobe.toTrip && (sampleCh == CH_W'(g)));
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      for (int c = 0; c < NUM_CH; c++) begin
        lastCode[c] <= '0;
        anchor[c]   <= '0;
        nbrSnap[c]  <= '0;
        stillCnt[c] <= '0;
      end
      seen   <= '0;
      snapOk <= '0;
      faultQ <= '0;
    end else begin
      for (int c = 0; c < NUM_CH; c++) begin
        if (selV[c]) begin
          lastCode[c] <= sampleCode;
          seen[c]     <= 1'b1;
          if (quietV[c]) begin
            if (stillCnt[c] != '1) stillCnt[c] <= stillCnt[c] + 1'b1;
            if (!snapOk[c] && seenNbrV[c]) begin
              nbrSnap[c] <= lastCode[nbrV[c*CH_W +: CH_W]];
              snapOk[c]  <= 1'b1;
            end
          end else begin
            anchor[c]   <= sampleCode;
            stillCnt[c] <= '0;
            nbrSnap[c]  <= lastCode[nbrV[c*CH_W +: CH_W]];
            snapOk[c]   <= seenNbrV[c];
          end
        end
      end
      faultQ <= (faultQ & ~clearFault) | setV;
    end
  end

  assign sensorFault = faultQ;

  // R1
  rail_flag_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (strobe.readEn && sampleCode <= railMargin) |=> sensorFault[$past(sampleCh)]);

  // R9
  sticky_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (($past(sensorFault) & ~$past(clearFault) & ~sensorFault) == '0));
endmodule

// File: rtl/tsense_guard.sv
module tsense_guard #(
  parameter int NUM_CH  = 4,
  parameter int CODE_W  = 12,
  parameter int STILL_W = 8,
  parameter int RETRY_W = 4,
  localparam int CH_W   = (NUM_CH > 1) ? $clog2(NUM_CH) : 1
) (
  input  logic                   clk,
  input  logic                   rst_n,
  input  logic                   sampleValid,
  input  logic [CH_W-1:0]        sampleCh,
  input  logic [CODE_W-1:0]      sampleCode,
  input  logic                   sampleTimeout,
  input  logic [CODE_W-1:0]      railMargin,
  input  logic [CODE_W-1:0]      stillDelta,
  input  logic [CODE_W-1:0]      moveDelta,
  input  logic [STILL_W-1:0]     stuckSamples,
  input  logic [RETRY_W-1:0]     retryLimit,
  input  logic [NUM_CH-1:0]      digitalMask,
  input  logic [NUM_CH-1:0]      keyMask,
  input  logic [NUM_CH-1:0]      nbrOverride,
  input  logic [NUM_CH*CH_W-1:0] nbrIndex,
  input  logic [NUM_CH-1:0]      clearFault,
  output logic [NUM_CH-1:0]      sensorFault,
  output logic                   keyLost
);
  tsg_pkg::tsgStrobe_t strobe;

  tsg_ctrl #(.NUM_CH(NUM_CH), .RETRY_W(RETRY_W)) uCtrl (
    .clk(clk), .rst_n(rst_n), .sampleValid(sampleValid),
    .sampleTimeout(sampleTimeout), .sampleCh(sampleCh),
    .digitalMask(digitalMask), .retryLimit(retryLimit), .strobe(strobe)
  );

  tsg_dpath #(.NUM_CH(NUM_CH), .CODE_W(CODE_W), .STILL_W(STILL_W)) uDpath (
    .clk(clk), .rst_n(rst_n), .strobe(strobe), .sampleCh(sampleCh),
    .sampleCode(sampleCode), .railMargin(railMargin), .stillDelta(stillDelta),
    .moveDelta(moveDelta), .stuckSamples(stuckSamples),
    .nbrOverride(nbrOverride), .nbrIndex(nbrIndex),
    .clearFault(clearFault), .sensorFault(sensorFault)
  );

  assign keyLost = |(sensorFault & keyMask);

  // R10
  key_lost_chk: assert property (@(posedge clk) disable iff (!rst_n)
    keyLost |-> (sensorFault != '0));
endmodule

// File: tb/tsense_guard_test.sv
`timescale 1ns/1ps
module tsense_guard_test;
  localparam int NUM_CH = 4;
  localparam int CODE_W = 12;
  localparam int CH_W = 2;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic sampleValid = 1'b0;
  logic [CH_W-1:0] sampleCh = '0;
  logic [CODE_W-1:0] sampleCode = '0;
  logic sampleTimeout = 1'b0;
  logic [CODE_W-1:0] railMargin = 12'd16;
  logic [CODE_W-1:0] stillDelta = 12'd2;
  logic [CODE_W-1:0] moveDelta = 12'd20;
  logic [7:0] stuckSamples = 8'd4;
  logic [3:0] retryLimit = 4'd3;
  logic [NUM_CH-1:0] digitalMask = 4'b0100;
  logic [NUM_CH-1:0] keyMask = 4'b0100;
  logic [NUM_CH-1:0] nbrOverride = '0;
  logic [NUM_CH*CH_W-1:0] nbrIndex = '0;
  logic [NUM_CH-1:0] clearFault = '0;
  logic [NUM_CH-1:0] sensorFault;
  logic keyLost;

  int tests = 0;
  int fails = 0;

  always #4 clk = ~clk;

  tsense_guard uut (
    .clk(clk), .rst_n(rst_n), .sampleValid(sampleValid), .sampleCh(sampleCh),
    .sampleCode(sampleCode), .sampleTimeout(sampleTimeout),
    .railMargin(railMargin), .stillDelta(stillDelta), .moveDelta(moveDelta),
    .stuckSamples(stuckSamples), .retryLimit(retryLimit),
    .digitalMask(digitalMask), .keyMask(keyMask), .nbrOverride(nbrOverride),
    .nbrIndex(nbrIndex), .clearFault(clearFault),
    .sensorFault(sensorFault), .keyLost(keyLost)
  );

  task automatic check(input string req, input int act, input int exp);
    tests++;
    if (act != exp) begin
      fails++;
      $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
    end
  endtask

  task automatic doReset();
    @(negedge clk);
    rst_n = 1'b0;
    repeat (2) @(negedge clk);
    rst_n = 1'b1;
  endtask

  task automatic send(input int ch, input int code, input bit to);
    sampleCh = CH_W'(ch);
    sampleCode = CODE_W'(code);
    sampleTimeout = to;
    sampleValid = 1'b1;
    @(negedge clk);
    sampleValid = 1'b0;
    sampleTimeout = 1'b0;
  endtask

  task automatic clearBits(input logic [NUM_CH-1:0] m);
    clearFault = m;
    @(negedge clk);
    clearFault = '0;
  endtask

  initial begin
    #1500000;
    fails++;
    $display("FAIL watchdog expired");
    $display("[TB] %0d tests run, %0d failed", tests, fails);
    $finish;
  end

  initial begin
    doReset();
    check("reset sensorFault", sensorFault, 0);
    check("reset keyLost", keyLost, 0);

    // R1 rail sweep on channel 0 around both boundaries; R10 channel 0 not key
    for (int code = 0; code <= 40; code++) begin
      send(0, code, 1'b0);
      check("R1 low rail", sensorFault[0], (code <= 16) ? 1 : 0);
      check("R10 non-key", keyLost, 0);
      clearBits(4'b0001);
    end
    for (int code = 4050; code <= 4095; code++) begin
      send(0, code, 1'b0);
      check("R1 high rail", sensorFault[0], (code >= 4079) ? 1 : 0);
      clearBits(4'b0001);
    end

    // R2 stuck channel 0, neighbour channel 1 moves 30 per step
    doReset();
    send(1, 1000, 1'b0);
    send(0, 2000, 1'b0);
    for (int k = 1; k <= 6; k++) begin
      send(1, 1000 + 30 * k, 1'b0);
      send(0, 2000 + (k % 2), 1'b0);
      check("R2 stuck window", sensorFault[0], (k >= 4) ? 1 : 0);
      check("R4 default nbr of ch1 unseen", sensorFault[1], 0);
    end

    // R3 quiet neighbour: never stuck
    doReset();
    send(1, 1000, 1'b0);
    send(0, 2000, 1'b0);
    for (int k = 1; k <= 8; k++) begin
      send(1, 1000 + (k % 3), 1'b0);
      send(0, 2000, 1'b0);
      check("R3 quiet nbr", sensorFault[0], 0);
    end

    // R5 override channel 0 -> channel 3 (quiet), channel 1 moving: no flag
    doReset();
    nbrOverride = 4'b0001;
    nbrIndex = {2'd0, 2'd0, 2'd0, 2'd3};
    send(3, 500, 1'b0);
    send(1, 900, 1'b0);
    send(0, 2000, 1'b0);
    for (int k = 1; k <= 6; k++) begin
      send(1, 900 + 30 * k, 1'b0);
      send(0, 2000, 1'b0);
      check("R5 override ignores ch1", sensorFault[0], 0);
    end
    // R5 override with channel 3 moving: flag at 4th still sample
    doReset();
    send(3, 500, 1'b0);
    send(0, 2000, 1'b0);
    for (int k = 1; k <= 5; k++) begin
      send(3, 500 + 30 * k, 1'b0);
      send(0, 2000, 1'b0);
      check("R5 override ch3 moves", sensorFault[0], (k >= 4) ? 1 : 0);
    end
    nbrOverride = '0;
    nbrIndex = '0;

    // R4 wrap: channel 3 uses channel 0
    doReset();
    send(0, 1500, 1'b0);
    send(3, 3000, 1'b0);
    for (int k = 1; k <= 5; k++) begin
      send(0, 1500 + 30 * k, 1'b0);
      send(3, 3000, 1'b0);
      check("R4 wrap nbr", sensorFault[3], (k >= 4) ? 1 : 0);
      check("R4 ch0 clean", sensorFault[0], 0);
    end

    // R6 retry limit on digital channel 2; R10 key channel
    doReset();
    for (int k = 1; k <= 4; k++) begin
      send(2, 0, 1'b1);
      check("R6 timeout run", sensorFault[2], (k >= 4) ? 1 : 0);
      check("R10 keyLost", keyLost, (k >= 4) ? 1 : 0);
    end
    // R9 sticky through good read, other-bit clear leaves it, own clear drops it
    send(2, 2000, 1'b0);
    check("R9 sticky", sensorFault[2], 1);
    clearBits(4'b1011);
    check("R9 other clear", sensorFault[2], 1);
    clearBits(4'b0100);
    check("R9 clear", sensorFault[2], 0);
    check("R10 keyLost drops", keyLost, 0);

    // R9 set wins over clear in the same cycle
    send(2, 2000, 1'b0);
    clearFault = 4'b0100;
    send(2, 5, 1'b0);
    clearFault = '0;
    check("R9 set beats clear", sensorFault[2], 1);

    // R7 good read restarts the run
    doReset();
    for (int k = 0; k < 3; k++) send(2, 0, 1'b1);
    send(2, 2000, 1'b0);
    for (int k = 1; k <= 4; k++) begin
      send(2, 0, 1'b1);
      check("R7 count restart", sensorFault[2], (k >= 4) ? 1 : 0);
    end

    // R8 timeouts on analog channel 3 ignored; its good read then normal
    doReset();
    for (int k = 0; k < 10; k++) send(3, 0, 1'b1);
    check("R8 analog timeouts", sensorFault, 0);
    check("R8 keyLost", keyLost, 0);

    $display("[TB] %0d tests run, %0d failed", tests, fails);
    $finish;
  end
endmodule